// File: doc/BRIEF.md
# Correctable-Error Leak Generator

This block slowly drains a saturating count of correctable errors. A wide free-running cycle timer is built from a low prescaler stage and a high stage. The high stage moves forward only when the prescaler wraps. Two one-hot selector inputs each name one bit of the high stage. When both named bits are set at the same time, the block raises an internal primary strobe and restarts the whole timer from zero. A two-bit divider setting then groups primary strobes, and each complete group produces one single-cycle leak pulse. Each leak pulse lowers the error count by one.

The error count rises by one on each increment request. It stops at its maximum, and it stops at zero when leaking. The period of the drain is therefore set by which two bits are selected and by the divider setting, not by a compare value.

Every pin is a plain control or status level. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. Any input may change on any cycle.

Top module: `ce_leak_top`

## Requirements
- R1: A synchronous reset clears the prescaler, the high stage, the group counter and the error count, and holds `leak_pulse` low.
- R2: With both selectors valid, the primary strobe fires when the timer value reaches V·2^PRE_W, where V = `sel_a | sel_b`. The timer then restarts from zero, so strobes repeat every V·2^PRE_W + 1 cycles.
- R3: `leak_div` sets the number of primary strobes per leak pulse: 2'b00 gives 4, 2'b01 gives 1, 2'b10 gives 2 and 2'b11 gives 3.
- R4: `leak_pulse` is high for exactly one cycle, in the cycle after the strobe that completes a group. After a reset it therefore first rises n·(V·2^PRE_W + 1) cycles after the first clock edge with reset low.
- R5: If either selector is all zeros, no strobe and no leak pulse are produced.
- R6: If either selector has more than one bit set, it is invalid, and no strobe and no leak pulse are produced.
- R7: Any change of `leak_div` clears the group counter, so counting starts over from the next strobe.
- R8: A leak pulse without an increment lowers `err_count` by exactly one. At zero the count stays at zero.
- R9: An increment without a leak raises `err_count` by one. At 2^CNT_W−1 the count stays there.
- R10: When an increment and a leak pulse fall in the same cycle, `err_count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | HI_W | One-hot selector for the first high-stage bit |
| sel_b | input | HI_W | One-hot selector for the second high-stage bit |
| leak_div | input | 2 | Strobes-per-leak setting |
| err_inc | input | 1 | Increment request for the error count |
| leak_pulse | output | 1 | Single-cycle leak pulse |
| err_count | output | CNT_W | Saturating correctable-error count |

## Verification
The bench sweeps every selector pair in a reduced configuration, including pairs that name the same bit, against all four divider codes. For each combination it measures both the delay from reset to the first leak and the interval between leaks. The delay separates an off-by-one in the prescaler carry, the restart or the output register. The interval separates the non-monotonic divider codes from one another. Zero and multi-bit selectors are checked for silence over long windows. A divider change made partway through a group shows whether the group counter is cleared. Counts driven into both limits, and an increment placed on the exact leak cycle, separate the saturation rules from the rule for simultaneous events.

// File: rtl/ce_leak_pkg.sv
package ce_leak_pkg;
  localparam int DIV_W = 2;
  typedef logic [DIV_W-1:0] div_t;

  // strobes needed per leak pulse; code zero stands for four
  function automatic logic [DIV_W:0] div_need(input div_t code);
    if (code == '0) return (DIV_W+1)'(4);
    else            return {1'b0, code};
  endfunction
endpackage

// File: rtl/ce_leak_timer.sv
module ce_leak_timer #(
  parameter int PRE_W = 11,
  parameter int HI_W  = 42
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HI_W-1:0] sel_a,
  input  logic [HI_W-1:0] sel_b,
  output logic            cfg_ok,
  output logic            strobe
);
  logic [PRE_W-1:0] pre_q;
  logic [HI_W-1:0]  hi_q;
  logic [HI_W-1:0]  hit_a, hit_b;
  logic             ok_a, ok_b;

  // exactly one bit set: nonzero and clearing the lowest set bit leaves nothing
  assign ok_a   = (|sel_a) && ~|(sel_a & (sel_a - HI_W'(1)));
  assign ok_b   = (|sel_b) && ~|(sel_b & (sel_b - HI_W'(1)));
  assign cfg_ok = ok_a && ok_b;

  for (genvar i = 0; i < HI_W; i++) begin : g_hit
    assign hit_a[i] = sel_a[i] & hi_q[i];
    assign hit_b[i] = sel_b[i] & hi_q[i];
  end

  assign strobe = cfg_ok && (|hit_a) && (|hit_b);

  always_ff @(posedge clk) begin
    if (rst || !cfg_ok || strobe) begin
      pre_q <= '0;
      hi_q  <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (&pre_q) hi_q <= hi_q + HI_W'(1);
    end
  end
endmodule

// File: rtl/ce_leak_divider.sv
module ce_leak_divider
  import ce_leak_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  div_t leak_div,
  output logic leak_q
);
  div_t           div_q;
  logic [DIV_W-1:0] grp_q;
  logic [DIV_W:0]   need;
  logic             last;

  assign need = div_need(leak_div);
  assign last = ({1'b0, grp_q} == need - (DIV_W+1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q  <= '0;
      leak_q <= 1'b0;
      div_q  <= leak_div;
    end else begin
      div_q  <= leak_div;
      leak_q <= 1'b0;
      if (leak_div != div_q) begin
        grp_q <= '0;
      end else if (strobe) begin
        if (last) begin
          grp_q  <= '0;
          leak_q <= 1'b1;
        end else begin
          grp_q <= grp_q + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ce_err_counter.sv
module ce_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (count != TOP) count <= count + CNT_W'(1);
        2'b01:   if (count != '0)  count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ce_leak_top.sv
module ce_leak_top #(
  parameter int PRE_W = 11,
  parameter int HI_W  = 42,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HI_W-1:0]  sel_a,
  input  logic [HI_W-1:0]  sel_b,
  input  logic [1:0]       leak_div,
  input  logic             err_inc,
  output logic             leak_pulse,
  output logic [CNT_W-1:0] err_count
);
  logic cfg_ok;
  logic prim_strobe;

  ce_leak_timer #(.PRE_W(PRE_W), .HI_W(HI_W)) u_timer (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b),
    .cfg_ok(cfg_ok), .strobe(prim_strobe)
  );

  ce_leak_divider u_div (
    .clk(clk), .rst(rst), .strobe(prim_strobe),
    .leak_div(leak_div), .leak_q(leak_pulse)
  );

  ce_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(err_inc), .dec(leak_pulse),
    .count(err_count)
  );
endmodule

// File: rtl/ce_leak_checker.sv
module ce_leak_checker #(
  parameter int HI_W  = 42,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [HI_W-1:0]  sel_a,
  input logic [HI_W-1:0]  sel_b,
  input logic             err_inc,
  input logic             leak_pulse,
  input logic [CNT_W-1:0] err_count,
  input logic             prim_strobe
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic sel_ok;
  assign sel_ok = $onehot(sel_a) && $onehot(sel_b);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (err_count == '0 && !leak_pulse));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    leak_pulse |=> !leak_pulse);

  p_pulse_follows_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    leak_pulse |-> $past(prim_strobe));

  p_silent_when_bad_sel_r6: assert property (@(posedge clk) disable iff (rst)
    !sel_ok |=> !leak_pulse);

  p_leak_dec_r8: assert property (@(posedge clk) disable iff (rst)
    (leak_pulse && !err_inc && err_count != '0) |=> err_count == $past(err_count) - CNT_W'(1));

  p_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (leak_pulse && !err_inc && err_count == '0) |=> err_count == '0);

  p_ceiling_r9: assert property (@(posedge clk) disable iff (rst)
    (err_inc && !leak_pulse && err_count == TOP) |=> err_count == TOP);

  p_both_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (err_inc && leak_pulse) |=> $stable(err_count));
endmodule

bind ce_leak_top ce_leak_checker #(.HI_W(HI_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .err_inc(err_inc),
  .leak_pulse(leak_pulse), .err_count(err_count), .prim_strobe(prim_strobe)
);

// File: tb/ce_leak_top_bench.sv
`timescale 1ns/1ps
module ce_leak_top_bench;
  localparam int PRE_W = 2;
  localparam int HI_W  = 5;
  localparam int CNT_W = 3;
  localparam int TOPV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [HI_W-1:0]  sel_a = '0;
  logic [HI_W-1:0]  sel_b = '0;
  logic [1:0]       leak_div = 2'b01;
  logic             err_inc = 1'b0;
  logic             leak_pulse;
  logic [CNT_W-1:0] err_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ce_leak_top #(.PRE_W(PRE_W), .HI_W(HI_W), .CNT_W(CNT_W)) u_ce_leak_top (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .leak_div(leak_div),
    .err_inc(err_inc), .leak_pulse(leak_pulse), .err_count(err_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // counts negedges until leak_pulse is seen high; returns limit+1 if never
  task automatic wait_leak(input int limit, output int cyc);
    cyc = 0;
    while (cyc <= limit) begin
      @(negedge clk);
      cyc++;
      if (leak_pulse) return;
    end
  endtask

  function automatic int need_of(input int code);
    return (code == 0) ? 4 : code;
  endfunction

  initial begin
    int c1, c2, per, n;
    // R1: reset state, including after the count was raised
    do_reset();
    @(negedge clk);
    check("R1 count", err_count, 0);
    check("R1 pulse", leak_pulse, 0);
    err_inc = 1'b1; repeat (3) @(negedge clk); err_inc = 1'b0;
    do_reset(); @(negedge clk);
    check("R1 count after raise", err_count, 0);

    // R2/R3/R4 sweep over all selector pairs and divider codes
    for (int a = 0; a < HI_W; a++) begin
      for (int b = a; b < HI_W; b++) begin
        for (int d = 0; d < 4; d++) begin
          sel_a = HI_W'(1) << a;
          sel_b = HI_W'(1) << b;
          leak_div = 2'(d);
          do_reset();
          per = (((1 << a) | (1 << b)) << PRE_W) + 1;
          n = need_of(d);
          wait_leak(4000, c1);
          check($sformatf("R4 first leak a=%0d b=%0d div=%0d", a, b, d), c1, n * per);
          wait_leak(4000, c2);
          check($sformatf("R2 R3 interval a=%0d b=%0d div=%0d", a, b, d), c2, n * per);
        end
      end
    end

    // R4: pulse lasts one cycle
    sel_a = 5'b00001; sel_b = 5'b00010; leak_div = 2'b01;
    do_reset();
    wait_leak(4000, c1);
    @(negedge clk);
    check("R4 single cycle", leak_pulse, 0);

    // R5: zero selectors
    sel_a = '0; sel_b = '0; do_reset();
    wait_leak(600, c1);
    check("R5 both zero silent", c1, 601);
    sel_a = 5'b00100; sel_b = '0; do_reset();
    wait_leak(600, c1);
    check("R5 one zero silent", c1, 601);

    // R6: multi-bit selector
    sel_a = 5'b00011; sel_b = 5'b00001; do_reset();
    wait_leak(600, c1);
    check("R6 multi-bit silent", c1, 601);
    sel_a = 5'b00010; sel_b = 5'b10100; do_reset();
    wait_leak(600, c1);
    check("R6 multi-bit b silent", c1, 601);

    // R7: divider change mid-group clears the group counter
    sel_a = 5'b00001; sel_b = 5'b00010; leak_div = 2'b10;
    per = (3 << PRE_W) + 1;
    do_reset();
    wait_leak(4000, c1);
    repeat (per + 3) @(negedge clk);
    leak_div = 2'b01;
    wait_leak(4000, c2);
    check("R7 restart after change", c2, per - 3);

    // R9: saturation at the top with leaking disabled
    sel_a = '0; sel_b = '0; do_reset();
    err_inc = 1'b1;
    for (int i = 1; i <= TOPV + 3; i++) begin
      @(negedge clk);
      check($sformatf("R9 inc step %0d", i), err_count, (i > TOPV) ? TOPV : i);
    end
    err_inc = 1'b0;

    // R8: each leak lowers by one and stops at zero
    sel_a = 5'b00001; sel_b = 5'b00010; leak_div = 2'b01;
    for (int k = 1; k <= TOPV + 2; k++) begin
      wait_leak(4000, c1);
      @(negedge clk);
      check($sformatf("R8 after leak %0d", k), err_count, (TOPV - k < 0) ? 0 : TOPV - k);
    end

    // R10: increment on the leak cycle holds the count
    sel_a = '0; sel_b = '0; do_reset();
    err_inc = 1'b1; repeat (3) @(negedge clk); err_inc = 1'b0;
    sel_a = 5'b00001; sel_b = 5'b00010; leak_div = 2'b01;
    wait_leak(4000, c1);
    err_inc = 1'b1;
    @(negedge clk);
    err_inc = 1'b0;
    check("R10 hold on both", err_count, 3);
    @(negedge clk);
    check("R10 steady after", err_count, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule